// File: doc/BRIEF.md
# Quadrature Timer Channel with Set/Reset PWM

This block is one 16-bit timer channel behind a small synchronous register port. The counter advances from one of three internal prescaled rates or from a chosen edge of an external clock input. It can also be switched into a two-phase counting mode. In that mode a pair of quadrature inputs drives the count up or down, and the rate and edge selections have no effect. Two compare registers, A and B, are compared against the live count at all times. A match can clear the counter, set a sticky flag and, in PWM mode, drive the output pin: A sets the pin and B resets it.

A sticky overflow flag records wrap-around of the counter. A mode bit decides whether a wrap from zero downward also counts as an overflow. Each of the three flags has its own interrupt enable and interrupt output. Software clears a flag by writing 0 to its bit.

Register map (addr): 0 CTRL, 1 MODE, 2 IEN, 3 FLAGS, 4 COUNT, 5 CMPA, 6 CMPB. Reads are combinational. A write takes effect at the clock edge where `wr_en` is high.

Top module: `qtmr_channel`

## Requirements
- R1: After reset, COUNT reads 0, CMPA and CMPB read 16'hFFFF, CTRL, IEN and FLAGS read 0, MODE reads 16'h0018 and `pwm_out` is 0. Counting is stopped because CTRL bit 6 (run) is 0.
- R2: With run=1 and phase mode off, CTRL[1:0] selects the count source: 0 counts every clock, 1 counts once in every 4 clocks, 2 counts once in every 16 clocks and 3 counts on the external clock input.
- R3: With source 3, CTRL[3:2] selects the external edge: 0 counts rising edges, 1 counts falling edges, and 2 or 3 count both edges.
- R4: With MODE bit 1 (phase) set, the count follows the quadrature inputs at four counts per input cycle. The sequence {a,b} = 00,10,11,01 counts up (a leads) and the reverse sequence counts down. A change of both inputs at once leaves the count unchanged. The CTRL source and edge fields are ignored in this mode.
- R5: A count-up step from 16'hFFFF to 0 sets FLAGS bit 2. A count-down step from 0 to 16'hFFFF also sets it when MODE bit 2 is 0, and does not set it when MODE bit 2 is 1.
- R6: CTRL[5:4] selects counter clearing: 1 clears on a match with CMPA, 2 clears on a match with CMPB, and 0 or 3 never clears. The counter reads 0 in the cycle after the matching value. Clearing takes precedence over counting.
- R7: FLAGS bit 0 and bit 1 are set by a CMPA match and a CMPB match respectively. All flags stay set until a write places 0 in their bit. Writing 1 to a flag bit leaves that flag unchanged.
- R8: Each interrupt output (`irq_cmp_a`, `irq_cmp_b`, `irq_ovf`) is high exactly when its flag and its IEN bit (bit 0, 1 or 2) are both 1.
- R9: With MODE bit 0 (pwm) set, `pwm_out` goes to 1 in the cycle after a CMPA match and to 0 in the cycle after a CMPB match. When both registers match in the same cycle, the output goes to 0.
- R10: With MODE bit 0 clear, `pwm_out` is held at 0 whatever the matches are.
- R11: MODE bits 4:3 ignore writes and always read as 1.
- R12: A write to COUNT loads the value at that edge and takes precedence over clearing and counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| ext_clk | input | 1 | External count clock, synchronous to clk |
| ph_a | input | 1 | Quadrature phase A, synchronous to clk |
| ph_b | input | 1 | Quadrature phase B, synchronous to clk |
| pwm_out | output | 1 | PWM output pin |
| irq_cmp_a | output | 1 | Compare A interrupt |
| irq_cmp_b | output | 1 | Compare B interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Several properties are checked on every cycle by the assertions: the counter reads zero after a clearing match, PWM set and reset follow the matches with B winning a tie, the pin is held low when PWM is off, flags stay set unless written, a both-inputs change never makes a step, an overflow flag raised in overflow-only mode always comes from 16'hFFFF, and the reserved MODE bits read as 1. Other behaviour can only be shown by the directed scenarios in the bench. These include the exact count rates of each prescaler setting, the counts for each external edge choice, and the up/down sequences of the quadrature mode with the clock select ignored. They also include underflow flagging in each direction setting, the pulse timing of the PWM waveform, and the interrupt gating.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_MODE  = 3'd1,
        A_IEN   = 3'd2,
        A_FLAGS = 3'd3,
        A_COUNT = 3'd4,
        A_CMPA  = 3'd5,
        A_CMPB  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {SRC_DIV1, SRC_DIV4, SRC_DIV16, SRC_EXT} clk_src_e;
    typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH, EDGE_BOTH_ALT} edge_e;
    typedef enum logic [1:0] {CLR_NONE, CLR_ON_A, CLR_ON_B, CLR_NONE_ALT} clr_e;

    typedef struct packed {
        logic     run;
        clr_e     clr;
        edge_e    edg;
        clk_src_e src;
    } ctrl_t;

    typedef struct packed {
        logic ovf_up_only;
        logic phase;
        logic pwm;
    } mode_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int MODE_W = $bits(mode_t);
    localparam int FLAG_W = 3;
    localparam int F_A    = 0;
    localparam int F_B    = 1;
    localparam int F_OVF  = 2;

    // Position of a quadrature state in the forward cycle 00,10,11,01
    function automatic logic [1:0] quad_pos(input logic a, input logic b);
        return {b, a ^ b};
    endfunction

    // Returns {up, down} for a transition between two sampled states
    function automatic logic [1:0] quad_step(input logic pa, input logic pb,
                                             input logic a,  input logic b);
        logic [1:0] diff;
        diff = quad_pos(a, b) - quad_pos(pa, pb);
        return {diff == 2'd1, diff == 2'd3};
    endfunction

endpackage

// File: rtl/qtmr_tick_gen.sv
module qtmr_tick_gen
    import qtmr_pkg::*;
#(
    parameter int PSC_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src,
    input  edge_e    edg,
    input  logic     ext_in,
    output logic     tick
);
    logic [PSC_W-1:0] psc;
    logic             ext_q;
    logic             rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc   <= '0;
            ext_q <= 1'b0;
        end else begin
            psc   <= psc + 1'b1;
            ext_q <= ext_in;
        end
    end

    assign rise = ext_in & ~ext_q;
    assign fall = ~ext_in & ext_q;

    always_comb begin
        case (src)
            SRC_DIV1:  tick = 1'b1;
            SRC_DIV4:  tick = &psc[1:0];
            SRC_DIV16: tick = &psc[3:0];
            default: begin
                case (edg)
                    EDGE_RISE: tick = rise;
                    EDGE_FALL: tick = fall;
                    default:   tick = rise | fall;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/qtmr_quad_dec.sv
module qtmr_quad_dec
    import qtmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn
);
    logic a_q, b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= ph_a;
            b_q <= ph_b;
        end
    end

    assign {step_up, step_dn} = quad_step(a_q, b_q, ph_a, ph_b);

    // R4: a simultaneous change of both phases never produces a step
    assert_quad_no_double_R4: assert property (@(posedge clk) disable iff (rst)
        ((ph_a != a_q) && (ph_b != b_q)) |-> (!step_up && !step_dn));

endmodule

// File: rtl/qtmr_pwm_out.sv
module qtmr_pwm_out (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_hit,
    input  logic clr_hit,
    output logic pin
);
    always_ff @(posedge clk) begin
        if (rst || !en)   pin <= 1'b0;
        else if (clr_hit) pin <= 1'b0;
        else if (set_hit) pin <= 1'b1;
    end
endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
    import qtmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int PSC_W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         ext_clk,
    input  logic         ph_a,
    input  logic         ph_b,
    output logic         pwm_out,
    output logic         irq_cmp_a,
    output logic         irq_cmp_b,
    output logic         irq_ovf
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    ctrl_t              ctrl;
    mode_t              mode;
    logic [FLAG_W-1:0]  ien, flags, flag_set;
    logic [W-1:0]       cnt, cmp_a, cmp_b;
    logic               tick, q_up, q_dn;
    logic               match_a, match_b, clr_hit, inc, dec, cnt_wr, flag_wr;
    logic               wrap_up, wrap_dn;

    qtmr_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk(clk), .rst(rst), .src(ctrl.src), .edg(ctrl.edg),
        .ext_in(ext_clk), .tick(tick)
    );

    qtmr_quad_dec u_quad (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b),
        .step_up(q_up), .step_dn(q_dn)
    );

    assign match_a = (cnt == cmp_a);
    assign match_b = (cnt == cmp_b);
    assign clr_hit = ((ctrl.clr == CLR_ON_A) && match_a) ||
                     ((ctrl.clr == CLR_ON_B) && match_b);
    assign cnt_wr  = wr_en && (addr == A_COUNT);
    assign flag_wr = wr_en && (addr == A_FLAGS);
    assign inc     = ctrl.run && (mode.phase ? q_up : tick);
    assign dec     = ctrl.run && mode.phase && q_dn;
    assign wrap_up = inc && (cnt == ALL_ONES) && !clr_hit && !cnt_wr;
    assign wrap_dn = dec && (cnt == '0) && !clr_hit && !cnt_wr;

    assign flag_set[F_A]   = match_a;
    assign flag_set[F_B]   = match_b;
    assign flag_set[F_OVF] = wrap_up || (wrap_dn && !mode.ovf_up_only);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            mode  <= '0;
            ien   <= '0;
            flags <= '0;
            cnt   <= '0;
            cmp_a <= ALL_ONES;
            cmp_b <= ALL_ONES;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: ctrl  <= ctrl_t'(wdata[CTRL_W-1:0]);
                    A_MODE: mode  <= mode_t'(wdata[MODE_W-1:0]);
                    A_IEN:  ien   <= wdata[FLAG_W-1:0];
                    A_CMPA: cmp_a <= wdata;
                    A_CMPB: cmp_b <= wdata;
                    default: ;
                endcase
            end
            if (flag_wr) flags <= (flags & wdata[FLAG_W-1:0]) | flag_set;
            else         flags <= flags | flag_set;

            if (cnt_wr)       cnt <= wdata;
            else if (clr_hit) cnt <= '0;
            else if (inc)     cnt <= cnt + 1'b1;
            else if (dec)     cnt <= cnt - 1'b1;
        end
    end

    qtmr_pwm_out u_pwm (
        .clk(clk), .rst(rst), .en(mode.pwm),
        .set_hit(match_a), .clr_hit(match_b), .pin(pwm_out)
    );

    assign irq_cmp_a = flags[F_A]   & ien[F_A];
    assign irq_cmp_b = flags[F_B]   & ien[F_B];
    assign irq_ovf   = flags[F_OVF] & ien[F_OVF];

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl};
            A_MODE:  rdata = {{(W-MODE_W-2){1'b0}}, 2'b11, mode};
            A_IEN:   rdata = {{(W-FLAG_W){1'b0}}, ien};
            A_FLAGS: rdata = {{(W-FLAG_W){1'b0}}, flags};
            A_COUNT: rdata = cnt;
            A_CMPA:  rdata = cmp_a;
            A_CMPB:  rdata = cmp_b;
            default: rdata = '0;
        endcase
    end

    // R6: a clearing match leaves the counter at zero one cycle later
    assert_clear_after_match_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !cnt_wr) |=> (cnt == '0));

    // R9: match A alone sets the pin, match B resets it and wins a tie
    assert_pwm_set_R9: assert property (@(posedge clk) disable iff (rst)
        (mode.pwm && match_a && !match_b) |=> pwm_out);
    assert_pwm_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (mode.pwm && match_b) |=> !pwm_out);

    // R10: pin held low while PWM is disabled
    assert_pwm_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !mode.pwm |=> !pwm_out);

    // R7: a compare flag survives every cycle that does not write 0 to it
    assert_flag_a_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flags[F_A] && !(flag_wr && !wdata[F_A])) |=> flags[F_A]);

    // R5: in overflow-only mode a new overflow flag comes from the top value
    assert_ovf_from_top_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags[F_OVF]) && $past(mode.ovf_up_only)) |-> ($past(cnt) == ALL_ONES));

    // R11: reserved mode bits read as ones
    assert_mode_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (addr == A_MODE) |-> (rdata[4:3] == 2'b11));

endmodule

// File: tb/tb_qtmr_channel.sv
`timescale 1ns/1ps
module tb_qtmr_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        ext_clk = 1'b0;
    logic        ph_a = 1'b0;
    logic        ph_b = 1'b0;
    logic        pwm_out, irq_cmp_a, irq_cmp_b, irq_ovf;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] CTRL = 3'd0, MODE = 3'd1, IEN = 3'd2, FLAGS = 3'd3,
                           COUNT = 3'd4, CMPA = 3'd5, CMPB = 3'd6;

    qtmr_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .ph_a(ph_a), .ph_b(ph_b),
        .pwm_out(pwm_out), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b),
        .irq_ovf(irq_ovf)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quad(input logic a, input logic b);
        @(negedge clk);
        ph_a = a; ph_b = b;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(COUNT, v); check("R1", "count", v, 16'h0000);
        rd(CMPA, v);  check("R1", "cmpa", v, 16'hFFFF);
        rd(CMPB, v);  check("R1", "cmpb", v, 16'hFFFF);
        rd(CTRL, v);  check("R1", "ctrl", v, 16'h0000);
        rd(FLAGS, v); check("R1", "flags", v, 16'h0000);
        rd(MODE, v);  check("R1", "mode", v, 16'h0018);
        check("R1", "pwm_out", {15'd0, pwm_out}, 16'd0);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        for (int s = 0; s < 3; s++) begin
            wr(CTRL, 16'h0040 | 16'(s));
            wr(COUNT, 16'h0000);
            idle(16);
            rd(COUNT, v);
            check("R2", $sformatf("src %0d over 16 clocks", s), v,
                  (s == 0) ? 16'd16 : (s == 1) ? 16'd4 : 16'd1);
        end
        wr(CTRL, 16'h0000);
    endtask

    task automatic t_ext_edges();
        logic [15:0] v;
        for (int e = 0; e < 3; e++) begin
            wr(CTRL, 16'h0043 | 16'(e << 2));
            wr(COUNT, 16'h0000);
            for (int p = 0; p < 3; p++) begin
                @(negedge clk) ext_clk = 1'b1;
                idle(2);
                ext_clk = 1'b0;
                idle(2);
            end
            rd(COUNT, v);
            check("R3", $sformatf("edge select %0d", e), v, (e == 2) ? 16'd6 : 16'd3);
        end
        wr(CTRL, 16'h0000);
    endtask

    task automatic t_quad();
        logic [15:0] v;
        wr(MODE, 16'h0002);
        wr(CTRL, 16'h0040);      // source select would count every clock
        wr(COUNT, 16'd100);
        idle(4);
        rd(COUNT, v); check("R4", "idle phases ignore clock select", v, 16'd100);
        for (int k = 0; k < 2; k++) begin
            quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        end
        idle(1);
        rd(COUNT, v); check("R4", "forward 8 steps", v, 16'd108);
        quad(0, 1); quad(1, 1); quad(1, 0);
        idle(1);
        rd(COUNT, v); check("R4", "reverse 3 steps", v, 16'd105);
        quad(0, 1);
        idle(1);
        rd(COUNT, v); check("R4", "both-change ignored", v, 16'd105);
        quad(0, 0);
        idle(1);
        rd(COUNT, v); check("R4", "forward after skip", v, 16'd106);
    endtask

    task automatic t_ovf();
        logic [15:0] v;
        // overflow in normal mode, direction bit 0
        wr(MODE, 16'h0000);
        wr(CTRL, 16'h0000);
        wr(FLAGS, 16'h0000);
        wr(COUNT, 16'hFFFE);
        wr(CTRL, 16'h0040);
        idle(2);
        rd(COUNT, v); check("R5", "wrapped count", v, 16'h0000);
        rd(FLAGS, v); check("R5", "overflow flag", v & 16'h4, 16'h4);
        // underflow in phase mode, direction bit 0 -> flag
        wr(MODE, 16'h0002);
        wr(FLAGS, 16'h0000);
        wr(COUNT, 16'h0000);
        quad(0, 1);
        idle(1);
        rd(COUNT, v); check("R5", "underflow count", v, 16'hFFFF);
        rd(FLAGS, v); check("R5", "underflow flagged", v & 16'h4, 16'h4);
        // underflow with direction bit 1 -> no flag
        wr(MODE, 16'h0006);
        wr(COUNT, 16'h0000);
        wr(FLAGS, 16'h0000);
        quad(1, 1);
        idle(1);
        rd(COUNT, v); check("R5", "underflow count, up-only", v, 16'hFFFF);
        rd(FLAGS, v); check("R5", "underflow not flagged", v & 16'h4, 16'h0);
        // overflow with direction bit 1 -> flag
        quad(0, 1);
        idle(1);
        rd(COUNT, v); check("R5", "overflow count, up-only", v, 16'h0000);
        rd(FLAGS, v); check("R5", "overflow flagged, up-only", v & 16'h4, 16'h4);
        quad(0, 0);                 // one more up step, back to 00
        wr(MODE, 16'h0000);
        wr(CTRL, 16'h0000);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(CMPA, 16'd10);
        wr(CTRL, 16'h0050);         // run, clear on A, every clock
        wr(COUNT, 16'd5);
        idle(5);
        rd(COUNT, v); check("R6", "reaches A", v, 16'd10);
        idle(1);
        rd(COUNT, v); check("R6", "cleared after A", v, 16'd0);
        idle(1);
        rd(COUNT, v); check("R6", "counts on after clear", v, 16'd1);
        wr(CMPB, 16'd3);
        wr(CTRL, 16'h0060);         // clear on B
        wr(COUNT, 16'd0);
        idle(4);
        rd(COUNT, v); check("R6", "cleared after B", v, 16'd0);
        wr(CTRL, 16'h0040);         // no clear
        wr(COUNT, 16'd8);
        idle(4);
        rd(COUNT, v); check("R6", "no clear passes A", v, 16'd12);
        // R12: count write overrides counting
        wr(COUNT, 16'h1234);
        rd(COUNT, v); check("R12", "count load while running", v, 16'h1234);
        wr(CTRL, 16'h0000);
        wr(CMPA, 16'hFFFF);
        wr(CMPB, 16'hFFFF);
    endtask

    task automatic t_flags_irq();
        logic [15:0] v;
        wr(IEN, 16'h0000);
        wr(CMPA, 16'd7);
        wr(COUNT, 16'd7);
        wr(FLAGS, 16'h0000);        // match persists, flag A comes back
        idle(1);
        rd(FLAGS, v); check("R7", "flag A set by match", v & 16'h3, 16'h1);
        check("R8", "irq A masked", {15'd0, irq_cmp_a}, 16'd0);
        wr(IEN, 16'h0001);
        check("R8", "irq A enabled", {15'd0, irq_cmp_a}, 16'd1);
        check("R8", "irq B idle", {15'd0, irq_cmp_b}, 16'd0);
        wr(COUNT, 16'd0);
        idle(3);
        rd(FLAGS, v); check("R7", "flag A sticky", v & 16'h1, 16'h1);
        wr(FLAGS, 16'h0007);
        rd(FLAGS, v); check("R7", "write 1 keeps flag", v & 16'h1, 16'h1);
        wr(FLAGS, 16'h0000);
        rd(FLAGS, v); check("R7", "write 0 clears", v, 16'h0);
        check("R8", "irq A gone", {15'd0, irq_cmp_a}, 16'd0);
        wr(IEN, 16'h0000);
        wr(CMPA, 16'hFFFF);
    endtask

    task automatic t_pwm();
        logic [15:0] v;
        // R10: matches without PWM mode leave the pin low
        wr(CMPA, 16'd2);
        wr(CMPB, 16'd6);
        wr(CTRL, 16'h0060);
        wr(COUNT, 16'd0);
        for (int i = 0; i < 8; i++) begin
            idle(1);
            check("R10", $sformatf("pin low, cycle %0d", i), {15'd0, pwm_out}, 16'd0);
        end
        // R9: set on A=4, reset on B=8, clear on B
        wr(CTRL, 16'h0000);
        wr(COUNT, 16'd0);
        wr(CMPA, 16'd4);
        wr(CMPB, 16'd8);
        wr(MODE, 16'h0001);
        wr(CTRL, 16'h0060);
        idle(4);
        check("R9", "low before A", {15'd0, pwm_out}, 16'd0);
        idle(1);
        check("R9", "high after A", {15'd0, pwm_out}, 16'd1);
        idle(3);
        check("R9", "high until B", {15'd0, pwm_out}, 16'd1);
        idle(1);
        check("R9", "low after B", {15'd0, pwm_out}, 16'd0);
        rd(COUNT, v); check("R9", "period restart", v, 16'd0);
        idle(5);
        check("R9", "high again next period", {15'd0, pwm_out}, 16'd1);
        // R9: tie between A and B resolves to low
        wr(CTRL, 16'h0000);
        wr(CMPA, 16'd5);
        wr(CMPB, 16'd5);
        wr(COUNT, 16'd0);
        wr(FLAGS, 16'h0000);
        wr(CTRL, 16'h0040);
        for (int i = 0; i < 10; i++) begin
            idle(1);
            if (i >= 6)
                check("R9", $sformatf("tie keeps pin low, cycle %0d", i), {15'd0, pwm_out}, 16'd0);
        end
        rd(FLAGS, v); check("R7", "both compare flags on tie", v & 16'h3, 16'h3);
        wr(MODE, 16'h0000);
        idle(1);
        check("R10", "pin low after disable", {15'd0, pwm_out}, 16'd0);
        wr(CTRL, 16'h0000);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(MODE, 16'h0000);
        rd(MODE, v); check("R11", "write 0", v, 16'h0018);
        wr(MODE, 16'h0007);
        rd(MODE, v); check("R11", "write 7", v, 16'h001F);
        wr(MODE, 16'h0000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk) rst = 1'b0;
        idle(2);
        t_prescale();
        t_ext_edges();
        t_quad();
        t_ovf();
        t_clear();
        t_flags_irq();
        t_pwm();
        t_reserved();
        idle(2);
        finish_run();
    end

endmodule